// File: doc/BRIEF.md
# Translation Table Mapping Scanner

This block walks a two-level, short-descriptor virtual memory translation table and turns it into a list of mapped regions. It reads a first-level table one word at a time through a simple request/acknowledge port. It descends into every second-level table that a first-level entry points to. For each mapped region it emits one record holding the region kind, the virtual range, the physical range, the cacheability and shareability bits, and four decoded permission flags. The virtual and physical ranges are inclusive. Empty entries produce nothing. Repeated entries that belong to a 16 MB or 64 KB region already reported are stepped over, not re-read.

Software or a debug controller applies a table base and a scan length, then pulses `start`. The scan length is either an explicit entry count or a split value that trims the table the way a translation base control field does. The scanner then runs on its own. It stalls whenever the record consumer withholds `rec_ready`, and it pulses `done` once the last first-level index has been handled. On the record stream, a record is offered while `rec_valid` is high. It is transferred in any cycle where `rec_ready` is also high. While it waits, every record field is held steady and no memory read is issued.

Top module: `ttscan_top`

## Requirements
- R1: On `start` with `use_count`=1 and `entry_count` equal to 0 or above 4096, the block pulses `reject` for one cycle, stays idle and issues no read and no record; a count of 4096 is accepted.
- R2: The last first-level index scanned is `entry_count`-1 when `use_count`=1, and 0xFFF shifted right by `split_n` when `use_count`=0; no entry beyond it is read.
- R3: First-level entry i is read from `table_base`+4*i, starting at i=0. An entry whose bits [1:0] are 00 yields no record and moves to i+1.
- R4: A first-level entry with bit 1 set and bit 18 clear is a section. It yields kind 0, virtual start i<<20, physical start desc[31:20]<<20, size 1 MB, and moves to i+1.
- R5: A first-level entry with bit 1 and bit 18 set is a supersection. It yields kind 1, virtual start i<<20, physical start desc[31:24]<<24, size 16 MB, and moves to i+16 without reading the entries in between.
- R6: A first-level entry with bits [1:0]=01 points to a second-level table at {desc[31:10],10'b0}. Its 256 entries j are read from that address+4*j, and each has virtual start (i<<20)+(j<<12). After the table the scan moves to i+1.
- R7: A second-level entry with bits [1:0]=01 is a large page: kind 2, physical start desc[31:16]<<16, size 64 KB, moves to j+16. Bits [1:0]=1x give a small page: kind 3, physical start desc[31:12]<<12, size 4 KB, moves to j+1. Bits 00 are skipped.
- R8: `rec_attr` is {S,C,B}. C is bit 3 and B is bit 2 at both levels. S, AP[2] and AP[1:0] are bits 16, 15 and 11:10 in a first-level entry, and bits 10, 9 and 5:4 in a second-level entry.
- R9: `rec_perm` is {privileged read, privileged write, user read, user write}. With `afe`=1 reads are always allowed and writes are allowed when AP[2]=0. User access is denied when AP[1]=0 and follows the privileged rights when AP[1]=1.
- R10: With `afe`=0, AP[1:0]=00 gives 0000. Values 01, 10 and 11 grant privileged read. 10 adds user read and 11 adds user read and write. Any write right is removed when AP[2]=1.
- R11: While `rec_valid` is high and `rec_ready` is low, all record fields hold their values and `rd_valid` stays low.
- R12: `rec_va_end` and `rec_pa_end` equal the matching start plus the region size minus 1, wrapping at 32 bits.
- R13: `done` is high for exactly one cycle after the final index is handled. `busy` is low from that cycle on.
- R14: `rd_valid` with a stable `rd_addr` stays high until `rd_ack`. `rd_data` is taken in the `rd_ack` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (ignored while busy) |
| table_base | input | 32 | Physical address of first-level entry 0 |
| use_count | input | 1 | 1: length from entry_count, 0: length from split_n |
| entry_count | input | 13 | Number of first-level entries to scan |
| split_n | input | 3 | Table split value trimming the last index |
| afe | input | 1 | Selects the simplified permission model |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse at scan end |
| reject | output | 1 | One-cycle pulse for an invalid count |
| rd_valid | output | 1 | Word read request |
| rd_addr | output | 32 | Word read address |
| rd_ack | input | 1 | Read completes, rd_data valid |
| rd_data | input | 32 | Descriptor word |
| rec_valid | output | 1 | Record offered |
| rec_ready | input | 1 | Consumer accepts record |
| rec_kind | output | 2 | 0 section, 1 supersection, 2 large page, 3 small page |
| rec_va_start | output | 32 | First virtual address of region |
| rec_va_end | output | 32 | Last virtual address of region |
| rec_pa_start | output | 32 | First physical address of region |
| rec_pa_end | output | 32 | Last physical address of region |
| rec_attr | output | 3 | {S, C, B} |
| rec_perm | output | 4 | {priv read, priv write, user read, user write} |

## Verification
A corrupted entry index or page index shows up right away in the next `rd_addr`. Because the record's virtual start is built from the same indices, the first record after the fault carries a wrong address. A bad skip step, either 1 where 16 is due or the reverse, shows as an extra record or a missing record within one region's worth of reads. A bad end-of-scan compare shows as `done` arriving early, arriving late, or reads past the last index. Permission and attribute slips appear in the first record whose descriptor exercises the affected bit. The directed tables are built so that every kind, every AP code under both models and each skip boundary produces its own record.

// File: rtl/ttscan_pkg.sv
package ttscan_pkg;
  localparam int DESC_W = 32;

  typedef enum logic [1:0] {
    RK_SECTION = 2'd0,
    RK_SUPER   = 2'd1,
    RK_LARGE   = 2'd2,
    RK_SMALL   = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_L1,
    ST_L2,
    ST_EMIT
  } scan_state_e;
endpackage

// File: rtl/ttscan_limit.sv
module ttscan_limit #(
  parameter int L1_ENTRIES = 4096,
  localparam int IDX_W = $clog2(L1_ENTRIES),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             use_count,
  input  logic [CNT_W-1:0] entry_count,
  input  logic [2:0]       split_n,
  output logic [IDX_W-1:0] last_idx,
  output logic             bad
);
  logic [CNT_W-1:0] cnt_m1;

  assign cnt_m1 = entry_count - CNT_W'(1);
  assign bad = use_count &&
               ((entry_count == '0) || (entry_count > CNT_W'(L1_ENTRIES)));
  assign last_idx = use_count ? cnt_m1[IDX_W-1:0] : ({IDX_W{1'b1}} >> split_n);
endmodule

// File: rtl/ttscan_attr.sv
module ttscan_attr (
  input  logic [31:0] desc,
  input  logic        second_level,
  input  logic        afe,
  output logic [2:0]  attr,
  output logic [3:0]  perm
);
  logic       s_bit, ap2;
  logic [1:0] ap;

  assign s_bit = second_level ? desc[10] : desc[16];
  assign ap2   = second_level ? desc[9]  : desc[15];
  assign ap    = second_level ? desc[5:4] : desc[11:10];
  assign attr  = {s_bit, desc[3], desc[2]};

  always_comb begin
    if (afe) begin
      perm = {1'b1, !ap2, ap[1], ap[1] & !ap2};
    end else begin
      unique case (ap)
        2'b00:   perm = 4'b0000;
        2'b01:   perm = {1'b1, !ap2, 2'b00};
        2'b10:   perm = {1'b1, !ap2, 2'b10};
        default: perm = {1'b1, !ap2, 1'b1, !ap2};
      endcase
    end
  end
endmodule

// File: rtl/ttscan_top.sv
module ttscan_top
  import ttscan_pkg::*;
#(
  parameter int L1_ENTRIES = 4096,
  parameter int L2_ENTRIES = 256,
  parameter int SKIP       = 16,
  localparam int IDX_W = $clog2(L1_ENTRIES),
  localparam int CNT_W = IDX_W + 1,
  localparam int J_W   = $clog2(L2_ENTRIES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DESC_W-1:0] table_base,
  input  logic              use_count,
  input  logic [CNT_W-1:0]  entry_count,
  input  logic [2:0]        split_n,
  input  logic              afe,
  output logic              busy,
  output logic              done,
  output logic              reject,
  output logic              rd_valid,
  output logic [DESC_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [DESC_W-1:0] rd_data,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [1:0]        rec_kind,
  output logic [DESC_W-1:0] rec_va_start,
  output logic [DESC_W-1:0] rec_va_end,
  output logic [DESC_W-1:0] rec_pa_start,
  output logic [DESC_W-1:0] rec_pa_end,
  output logic [2:0]        rec_attr,
  output logic [3:0]        rec_perm
);
  localparam logic [IDX_W:0] IDX_ONE  = (IDX_W+1)'(1);
  localparam logic [IDX_W:0] IDX_SKIP = (IDX_W+1)'(SKIP);
  localparam logic [J_W-1:0] J_ONE    = J_W'(1);
  localparam logic [J_W-1:0] J_SKIP   = J_W'(SKIP);
  localparam logic [J_W-1:0] J_LIMIT  = J_W'(L2_ENTRIES);

  scan_state_e       state_q;
  logic [DESC_W-1:0] base_q, l2base_q;
  logic              afe_q;
  logic [IDX_W-1:0]  last_q;
  logic [IDX_W:0]    idx_q;
  logic [J_W-1:0]    j_q;
  region_e           kind_q;
  logic              done_q, reject_q;

  logic [IDX_W-1:0]  last_idx;
  logic              bad_count;
  logic [2:0]        cand_attr;
  logic [3:0]        cand_perm;

  ttscan_limit #(.L1_ENTRIES(L1_ENTRIES)) u_limit (
    .use_count(use_count), .entry_count(entry_count), .split_n(split_n),
    .last_idx(last_idx), .bad(bad_count)
  );

  ttscan_attr u_attr (
    .desc(rd_data), .second_level(state_q == ST_L2), .afe(afe_q),
    .attr(cand_attr), .perm(cand_perm)
  );

  // TEX and domain bits take no part in the scan
  logic tex_unused;
  assign tex_unused = ^rd_data[8:6];

  // ---------------- descriptor classification ----------------
  logic accept, is_empty, emit_load, l2_enter, skip_now;
  assign accept    = rd_valid && rd_ack;
  assign is_empty  = (rd_data[1:0] == 2'b00);
  assign emit_load = accept && ((state_q == ST_L1 && rd_data[1]) ||
                                (state_q == ST_L2 && !is_empty));
  assign l2_enter  = accept && state_q == ST_L1 && rd_data[1:0] == 2'b01;
  assign skip_now  = accept && is_empty;

  region_e           cand_kind;
  logic [DESC_W-1:0] cand_pa, cand_span, cand_va;
  always_comb begin
    if (state_q == ST_L1) cand_kind = rd_data[18] ? RK_SUPER : RK_SECTION;
    else                  cand_kind = (rd_data[1:0] == 2'b01) ? RK_LARGE : RK_SMALL;
    unique case (cand_kind)
      RK_SECTION: begin cand_pa = {rd_data[31:20], 20'b0}; cand_span = 32'h000F_FFFF; end
      RK_SUPER:   begin cand_pa = {rd_data[31:24], 24'b0}; cand_span = 32'h00FF_FFFF; end
      RK_LARGE:   begin cand_pa = {rd_data[31:16], 16'b0}; cand_span = 32'h0000_FFFF; end
      default:    begin cand_pa = {rd_data[31:12], 12'b0}; cand_span = 32'h0000_0FFF; end
    endcase
  end

  logic [DESC_W-1:0] va_l1;
  assign va_l1   = DESC_W'(idx_q[IDX_W-1:0]) << 20;
  assign cand_va = (state_q == ST_L2) ? (va_l1 | (DESC_W'(j_q[J_W-2:0]) << 12)) : va_l1;

  // ---------------- index advance ----------------
  logic emit_take, l1_kind;
  logic adv_l1, adv_l2, l2_wrap, finish;
  logic [IDX_W:0]   idx_next;
  logic [J_W-1:0]   j_next;

  assign emit_take = (state_q == ST_EMIT) && rec_ready;
  assign l1_kind   = (kind_q == RK_SECTION) || (kind_q == RK_SUPER);
  assign j_next    = j_q + ((state_q == ST_EMIT && kind_q == RK_LARGE) ? J_SKIP : J_ONE);
  assign idx_next  = idx_q + ((state_q == ST_EMIT && kind_q == RK_SUPER) ? IDX_SKIP : IDX_ONE);
  assign adv_l2    = (state_q == ST_L2 && skip_now) || (emit_take && !l1_kind);
  assign l2_wrap   = adv_l2 && (j_next >= J_LIMIT);
  assign adv_l1    = (state_q == ST_L1 && skip_now) || (emit_take && l1_kind) || l2_wrap;
  assign finish    = adv_l1 && (idx_next > {1'b0, last_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      base_q   <= '0;
      l2base_q <= '0;
      afe_q    <= 1'b0;
      last_q   <= '0;
      idx_q    <= '0;
      j_q      <= '0;
      kind_q   <= RK_SECTION;
      done_q   <= 1'b0;
      reject_q <= 1'b0;
      rec_va_start <= '0;
      rec_va_end   <= '0;
      rec_pa_start <= '0;
      rec_pa_end   <= '0;
      rec_attr     <= '0;
      rec_perm     <= '0;
    end else begin
      done_q   <= 1'b0;
      reject_q <= 1'b0;
      if (state_q == ST_IDLE && start) begin
        if (bad_count) begin
          reject_q <= 1'b1;
        end else begin
          base_q  <= table_base;
          afe_q   <= afe;
          last_q  <= last_idx;
          idx_q   <= '0;
          state_q <= ST_L1;
        end
      end
      if (emit_load) begin
        kind_q       <= cand_kind;
        rec_va_start <= cand_va;
        rec_va_end   <= cand_va + cand_span;
        rec_pa_start <= cand_pa;
        rec_pa_end   <= cand_pa + cand_span;
        rec_attr     <= cand_attr;
        rec_perm     <= cand_perm;
        state_q      <= ST_EMIT;
      end
      if (l2_enter) begin
        l2base_q <= {rd_data[31:10], 10'b0};
        j_q      <= '0;
        state_q  <= ST_L2;
      end
      if (adv_l2 && !l2_wrap) begin
        j_q     <= j_next;
        state_q <= ST_L2;
      end
      if (adv_l1) begin
        if (finish) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end else begin
          idx_q   <= idx_next;
          state_q <= ST_L1;
        end
      end
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign reject    = reject_q;
  assign rd_valid  = (state_q == ST_L1) || (state_q == ST_L2);
  assign rd_addr   = (state_q == ST_L2) ? (l2base_q + (DESC_W'(j_q[J_W-2:0]) << 2))
                                        : (base_q + (DESC_W'(idx_q[IDX_W-1:0]) << 2));
  assign rec_valid = (state_q == ST_EMIT);
  assign rec_kind  = kind_q;
endmodule

// File: rtl/ttscan_checker.sv
module ttscan_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        reject,
  input logic        rd_valid,
  input logic [31:0] rd_addr,
  input logic        rd_ack,
  input logic        rec_valid,
  input logic        rec_ready,
  input logic [1:0]  rec_kind,
  input logic [31:0] rec_va_start,
  input logic [31:0] rec_va_end,
  input logic [31:0] rec_pa_start,
  input logic [31:0] rec_pa_end,
  input logic [3:0]  rec_perm
);
  a_r11_hold_record: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_kind) &&
      $stable(rec_va_start) && $stable(rec_pa_start) && $stable(rec_perm));

  a_r11_no_read_while_offering: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> !rd_valid);

  a_r14_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ack |=> rd_valid && $stable(rd_addr));

  a_r12_equal_spans: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_va_end - rec_va_start) == (rec_pa_end - rec_pa_start));

  a_r4_section_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && rec_kind == 2'd0 |-> rec_va_start[19:0] == 20'd0 && rec_pa_start[19:0] == 20'd0);

  a_r10_write_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (!rec_perm[2] || rec_perm[3]) && (!rec_perm[0] || (rec_perm[1] && rec_perm[2])));

  a_r13_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy ##1 !done);

  a_r1_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> !busy && !rd_valid && !rec_valid);
endmodule

bind ttscan_top ttscan_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .reject(reject),
  .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ack(rd_ack),
  .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_kind(rec_kind),
  .rec_va_start(rec_va_start), .rec_va_end(rec_va_end),
  .rec_pa_start(rec_pa_start), .rec_pa_end(rec_pa_end), .rec_perm(rec_perm)
);

// File: tb/ttscan_top_test.sv
module ttscan_top_test;
  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] vs, ve, ps, pe;
    logic [2:0]  attr;
    logic [3:0]  perm;
  } rec_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] table_base = '0;
  logic        use_count = 1'b1;
  logic [12:0] entry_count = '0;
  logic [2:0]  split_n = '0;
  logic        afe = 1'b0;
  logic        busy, done, reject, rd_valid, rec_valid;
  logic [31:0] rd_addr;
  logic        rd_ack = 1'b0;
  logic [31:0] rd_data = '0;
  logic        rec_ready = 1'b1;
  logic [1:0]  rec_kind;
  logic [31:0] rec_va_start, rec_va_end, rec_pa_start, rec_pa_end;
  logic [2:0]  rec_attr;
  logic [3:0]  rec_perm;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int done_cnt = 0;
  int read_cnt = 0;
  logic [31:0] mem [logic [31:0]];
  rec_t  got[$];
  rec_t  exp[$];
  string exp_tag[$];

  always #2 clk = ~clk;

  ttscan_top uut (.*);

  // memory model: acknowledges one cycle after a request is seen
  always @(posedge clk) begin
    if (!rst_n) begin
      rd_ack <= 1'b0;
    end else begin
      rd_ack  <= rd_valid && !rd_ack;
      rd_data <= mem.exists(rd_addr) ? mem[rd_addr] : 32'h0;
    end
  end

  always @(negedge clk) begin
    if (rec_valid && rec_ready)
      got.push_back({rec_kind, rec_va_start, rec_va_end, rec_pa_start, rec_pa_end, rec_attr, rec_perm});
    if (done) done_cnt++;
    if (rd_valid && rd_ack) read_cnt++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual cycles %0d expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic push_exp(input logic [1:0] k, input logic [31:0] vs, input logic [31:0] span,
                          input logic [31:0] ps, input logic [2:0] at, input logic [3:0] pm,
                          input string tag);
    exp.push_back({k, vs, vs + span, ps, ps + span, at, pm});
    exp_tag.push_back(tag);
  endtask

  task automatic start_scan(input logic [31:0] b, input logic uc, input logic [12:0] cnt,
                            input logic [2:0] sn, input logic a);
    got.delete();
    exp.delete();
    exp_tag.delete();
    done_cnt = 0;
    read_cnt = 0;
    @(negedge clk);
    table_base = b; use_count = uc; entry_count = cnt; split_n = sn; afe = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk({req, " done reached"}, 32'(done), 32'd1);
    chk({req, " busy low at done"}, 32'(busy), 32'd0);
    repeat (3) @(negedge clk);
    chk("R13 single done pulse", done_cnt, 1);
  endtask

  task automatic compare_records();
    chk("R3 record count", got.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got.size(); i++) begin
      chk({exp_tag[i], " kind"},     32'(got[i].kind), 32'(exp[i].kind));
      chk({exp_tag[i], " va start"}, got[i].vs, exp[i].vs);
      chk({"R12 va end / ", exp_tag[i]}, got[i].ve, exp[i].ve);
      chk({exp_tag[i], " pa start"}, got[i].ps, exp[i].ps);
      chk({"R12 pa end / ", exp_tag[i]}, got[i].pe, exp[i].pe);
      chk({"R8 attr / ", exp_tag[i]}, 32'(got[i].attr), 32'(exp[i].attr));
      chk({"perm / ", exp_tag[i]}, 32'(got[i].perm), 32'(exp[i].perm));
    end
  endtask

  task automatic t_reset();
    chk("R13 reset busy", 32'(busy), 0);
    chk("R13 reset done", 32'(done), 0);
    chk("R14 reset rd_valid", 32'(rd_valid), 0);
    chk("R11 reset rec_valid", 32'(rec_valid), 0);
  endtask

  task automatic t_reject(input logic [12:0] cnt);
    start_scan(32'h0, 1'b1, cnt, 3'd0, 1'b0);
    chk("R1 reject pulse", 32'(reject), 1);
    chk("R1 stays idle", 32'(busy), 0);
    @(negedge clk);
    chk("R1 reject one cycle", 32'(reject), 0);
    repeat (4) @(negedge clk);
    chk("R1 no read after reject", read_cnt, 0);
    chk("R1 no record after reject", got.size(), 0);
  endtask

  task automatic t_mixed();
    mem.delete();
    mem[32'h10000] = 32'h12310C0A;  // section
    mem[32'h10008] = 32'hAB048402;  // supersection at i=2
    mem[32'h1000C] = 32'h55500002;  // covered by supersection, not read
    mem[32'h10048] = 32'h00020401;  // page table at i=18
    mem[32'h20400] = 32'h7654362E;  // small page j=0
    mem[32'h20404] = 32'h89AB0011;  // large page j=1
    mem[32'h20408] = 32'h22222002;  // covered by large page
    mem[32'h207FC] = 32'h11111003;  // small page j=255, bits 11
    mem[32'h1004C] = 32'hFFF00002;  // section i=19
    mem[32'h10050] = 32'h33300002;  // beyond count
    start_scan(32'h0001_0000, 1'b1, 13'd20, 3'd0, 1'b0);
    push_exp(2'd0, 32'h0000_0000, 32'h000F_FFFF, 32'h1230_0000, 3'b110, 4'b1111, "R4 R10 section");
    push_exp(2'd1, 32'h0020_0000, 32'h00FF_FFFF, 32'hAB00_0000, 3'b000, 4'b1000, "R5 R10 supersection");
    push_exp(2'd3, 32'h0120_0000, 32'h0000_0FFF, 32'h7654_3000, 3'b111, 4'b1010, "R6 R7 R10 small page");
    push_exp(2'd2, 32'h0120_1000, 32'h0000_FFFF, 32'h89AB_0000, 3'b000, 4'b1100, "R7 R10 large page");
    push_exp(2'd3, 32'h012F_F000, 32'h0000_0FFF, 32'h1111_1000, 3'b000, 4'b0000, "R7 R10 small page 11");
    push_exp(2'd0, 32'h0130_0000, 32'h000F_FFFF, 32'hFFF0_0000, 3'b000, 4'b0000, "R3 R12 section wrap");
    wait_done("R2");
    compare_records();
    // reads: 2 (i0,i1) + 1 (i2) + 1 (i18) + 256-15 (L2) + 1 (i19)
    chk("R5 R6 R7 read count", read_cnt, 246);
  endtask

  task automatic t_afe();
    mem.delete();
    mem[32'h0] = 32'h00100002;
    mem[32'h4] = 32'h00208802;
    mem[32'h8] = 32'h01040C02;
    start_scan(32'h0, 1'b1, 13'd4, 3'd0, 1'b1);
    push_exp(2'd0, 32'h0000_0000, 32'h000F_FFFF, 32'h0010_0000, 3'b000, 4'b1100, "R9 ap1=0");
    push_exp(2'd0, 32'h0010_0000, 32'h000F_FFFF, 32'h0020_0000, 3'b000, 4'b1010, "R9 ap2=1");
    push_exp(2'd1, 32'h0020_0000, 32'h00FF_FFFF, 32'h0100_0000, 3'b000, 4'b1111, "R9 supersection");
    wait_done("R9");
    compare_records();
  endtask

  task automatic t_split();
    mem.delete();
    mem[32'h4000] = 32'h00A00C02;
    mem[32'h407C] = 32'h00B00002;
    mem[32'h4080] = 32'h00C00002;
    start_scan(32'h4000, 1'b0, 13'd0, 3'd7, 1'b0);
    push_exp(2'd0, 32'h0000_0000, 32'h000F_FFFF, 32'h00A0_0000, 3'b000, 4'b1111, "R2 split first");
    push_exp(2'd0, 32'h01F0_0000, 32'h000F_FFFF, 32'h00B0_0000, 3'b000, 4'b0000, "R2 split last");
    wait_done("R2");
    compare_records();
    chk("R2 split read count", read_cnt, 32);
    start_scan(32'h4000, 1'b1, 13'd1, 3'd0, 1'b0);
    push_exp(2'd0, 32'h0000_0000, 32'h000F_FFFF, 32'h00A0_0000, 3'b000, 4'b1111, "R2 count one");
    wait_done("R2");
    compare_records();
  endtask

  task automatic t_full_count();
    mem.delete();
    mem[32'h0010_3FFC] = 32'h80000002;
    start_scan(32'h0010_0000, 1'b1, 13'd4096, 3'd0, 1'b0);
    chk("R1 4096 accepted", 32'(reject), 0);
    push_exp(2'd0, 32'hFFF0_0000, 32'h000F_FFFF, 32'h8000_0000, 3'b000, 4'b0000, "R1 R2 last of 4096");
    wait_done("R1");
    compare_records();
    chk("R2 full read count", read_cnt, 4096);
  endtask

  task automatic t_backpressure();
    logic [31:0] va_hold;
    int t = 0;
    mem.delete();
    mem[32'h0] = 32'h00100002;
    mem[32'h4] = 32'h00200002;
    rec_ready = 1'b0;
    start_scan(32'h0, 1'b1, 13'd2, 3'd0, 1'b0);
    while (!rec_valid && t < 100) begin
      @(negedge clk);
      t++;
    end
    va_hold = rec_va_start;
    repeat (6) begin
      @(negedge clk);
      chk("R11 record held", rec_va_start, va_hold);
      chk("R11 no read during stall", 32'(rd_valid), 0);
    end
    chk("R11 no done while stalled", done_cnt, 0);
    rec_ready = 1'b1;
    push_exp(2'd0, 32'h0000_0000, 32'h000F_FFFF, 32'h0010_0000, 3'b000, 4'b0000, "R11 first");
    push_exp(2'd0, 32'h0010_0000, 32'h000F_FFFF, 32'h0020_0000, 3'b000, 4'b0000, "R11 second");
    wait_done("R11");
    compare_records();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reject(13'd0);
    t_reject(13'd4097);
    t_mixed();
    t_afe();
    t_split();
    t_backpressure();
    t_full_count();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule